// File: doc/BRIEF.md
# Save-RAM Autosave Scheduler

This block decides when a battery-backed save-RAM region should be written back to mass storage. A separate scanner walks the region and presents one checksum per completed pass. The scheduler compares each pass result with the checksum of the last saved image. When they differ it waits for the memory to settle before asking for a save. If the memory never settles, a longer ceiling timer forces a save anyway. Holding the console reset button for long enough requests a save on demand.

Time is measured in ticks of a one-millisecond strobe. The quiet time, the forced-save ceiling and the long-press threshold are all parameters counted in those ticks. A save request is a one-cycle pulse. The storage side answers with a one-cycle `save_done` when the write has finished. Until that acknowledge arrives, no further request is issued. The checksum input has a valid strobe and no ready: the block accepts a pass result in every cycle, so the scanner never sees back-pressure. All other pins are plain synchronous levels or strobes.

Top module: `save_autosave_sched`

## Requirements
- R1: After reset, `save_req` is low and no save is outstanding.
- R2: The first pass result after reset becomes the saved reference, and it alone never causes a save.
- R3: The region counts as changed only while the latest pass result differs from the saved reference. A value that returns to the reference before a save is issued causes no save.
- R4: While changed, a request is issued in the cycle after the QUIET_MS-th tick that follows the last pass whose result differed from the previous pass.
- R5: While changed, a request is issued after FORCE_MS ticks of continuous change, even if pass results keep changing.
- R6: Holding `reset_btn` high through more than HOLD_MS ticks issues exactly one request per press, whether or not the region has changed. A shorter press issues none.
- R7: `save_req` is high for exactly one cycle per request.
- R8: No request is issued between a request and its `save_done`. A cause that arises in that interval is served after the acknowledge. A `save_done` with no save outstanding is ignored.
- R9: On `save_done`, the saved reference becomes the pass result that was current when the request was issued, not any later one.
- R10: A completed save restarts the forced-save timer, so continuous change after a save needs another FORCE_MS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sum_valid | input | 1 | One pass result is present on `sum_data` this cycle |
| sum_data | input | SUM_W | Checksum of the region for one completed pass |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| reset_btn | input | 1 | Console reset button, high while pressed, synchronous |
| save_done | input | 1 | One-cycle acknowledge that the write-back has finished |
| save_req | output | 1 | One-cycle request to write the region back |

## Verification
The bench checks the exact tick on which the quiet and forced timers fire. A design that counted one tick too few or too many would request early or late. A region that changes and then reverts to the reference must stay quiet; a design that latched "changed" would save it anyway. A change that arrives while a save is outstanding must be compared against the checksum captured when the request was issued. A design that committed the newest value would silently lose that change. A press held past the threshold must give one request, and a design that did not latch per press would repeat it. Causes that arise while busy must be held and released after the acknowledge, and the forced timer must restart on completion instead of firing again at once.

// File: rtl/autosave_pkg.sv
package autosave_pkg;

  // Reason chosen for the next write-back request.
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_QUIET  = 2'd1,
    CAUSE_FORCE  = 2'd2,
    CAUSE_MANUAL = 2'd3
  } save_cause_e;

endpackage

// File: rtl/as_tick_counter.sv
// Saturating millisecond counter; reached holds once LIMIT ticks were seen.
module as_tick_counter #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic reached
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && tick && (cnt_q < LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign reached = (cnt_q == LIM);
endmodule

// File: rtl/as_change_tracker.sv
// Keeps the latest pass result, the saved reference and the issue-time copy.
module as_change_tracker #(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sum_valid,
  input  logic [SUM_W-1:0] sum_data,
  input  logic             capture,
  input  logic             commit,
  output logic             dirty,
  output logic             pass_changed
);
  logic [SUM_W-1:0] last_q;
  logic [SUM_W-1:0] ref_q;
  logic [SUM_W-1:0] held_q;
  logic             ref_ok_q;

  assign pass_changed = sum_valid && (!ref_ok_q || (sum_data != last_q));
  assign dirty        = ref_ok_q && (last_q != ref_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q   <= '0;
      ref_q    <= '0;
      held_q   <= '0;
      ref_ok_q <= 1'b0;
    end else begin
      if (capture) held_q <= last_q;
      if (commit)  ref_q  <= held_q;
      if (sum_valid) begin
        last_q <= sum_data;
        if (!ref_ok_q) begin
          ref_q    <= sum_data;
          ref_ok_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/as_press_detector.sv
// One pulse per press once the button is held through more than HOLD_MS ticks.
module as_press_detector #(
  parameter int HOLD_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  input  logic tick,
  output logic long_press
);
  logic held_long;
  logic fired_q;

  as_tick_counter #(.LIMIT(HOLD_MS + 1)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!btn),
    .run     (btn),
    .tick    (tick),
    .reached (held_long)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         fired_q <= 1'b0;
    else if (!btn)      fired_q <= 1'b0;
    else if (held_long) fired_q <= 1'b1;
  end

  assign long_press = btn && held_long && !fired_q;
endmodule

// File: rtl/save_autosave_sched.sv
module save_autosave_sched #(
  parameter int SUM_W    = 16,
  parameter int QUIET_MS = 1000,
  parameter int FORCE_MS = 30000,
  parameter int HOLD_MS  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sum_valid,
  input  logic [SUM_W-1:0] sum_data,
  input  logic             tick_ms,
  input  logic             reset_btn,
  input  logic             save_done,
  output logic             save_req
);
  import autosave_pkg::*;

  logic        dirty_w;
  logic        pass_changed_w;
  logic        quiet_ok_w;
  logic        force_ok_w;
  logic        long_press_w;
  logic        busy_q;
  logic        man_pend_q;
  logic        req_q;
  logic        commit_w;
  logic        issue_w;
  save_cause_e cause_w;

  assign commit_w = busy_q && save_done;

  as_change_tracker #(.SUM_W(SUM_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .sum_valid    (sum_valid),
    .sum_data     (sum_data),
    .capture      (issue_w),
    .commit       (commit_w),
    .dirty        (dirty_w),
    .pass_changed (pass_changed_w)
  );

  // Quiet timer: restarts whenever a pass brings a new value.
  as_tick_counter #(.LIMIT(QUIET_MS)) u_quiet (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pass_changed_w),
    .run     (1'b1),
    .tick    (tick_ms),
    .reached (quiet_ok_w)
  );

  // Ceiling timer: runs only while changed, restarts on each completed save.
  as_tick_counter #(.LIMIT(FORCE_MS)) u_force (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!dirty_w || commit_w),
    .run     (dirty_w),
    .tick    (tick_ms),
    .reached (force_ok_w)
  );

  as_press_detector #(.HOLD_MS(HOLD_MS)) u_press (
    .clk        (clk),
    .rst_n      (rst_n),
    .btn        (reset_btn),
    .tick       (tick_ms),
    .long_press (long_press_w)
  );

  always_comb begin
    cause_w = CAUSE_NONE;
    if (man_pend_q)                   cause_w = CAUSE_MANUAL;
    else if (dirty_w && force_ok_w)   cause_w = CAUSE_FORCE;
    else if (dirty_w && quiet_ok_w)   cause_w = CAUSE_QUIET;
  end

  assign issue_w = !busy_q && (cause_w != CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      man_pend_q <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      req_q <= issue_w;
      if (issue_w)       busy_q <= 1'b1;
      else if (commit_w) busy_q <= 1'b0;
      if (long_press_w)                           man_pend_q <= 1'b1;
      else if (issue_w && cause_w == CAUSE_MANUAL) man_pend_q <= 1'b0;
    end
  end

  assign save_req = req_q;
endmodule

// File: rtl/as_sched_checker.sv
module as_sched_checker (
  input logic clk,
  input logic rst_n,
  input logic save_req,
  input logic save_done,
  input logic dirty,
  input logic man_pend,
  input logic long_press,
  input logic quiet_ok,
  input logic force_ok,
  input logic busy
);
  logic outstanding_q;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding_q <= 1'b0;
    else        outstanding_q <= (outstanding_q || save_req) && !save_done;
  end

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |=> !save_req);

  p_no_reissue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q |-> !save_req);

  p_cause_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |-> $past(dirty || man_pend));

  p_quiet_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty && quiet_ok && !busy) |=> save_req);

  p_force_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty && force_ok && !busy) |=> save_req);

  p_press_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    long_press |=> !long_press);
endmodule

bind save_autosave_sched as_sched_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .save_req   (save_req),
  .save_done  (save_done),
  .dirty      (dirty_w),
  .man_pend   (man_pend_q),
  .long_press (long_press_w),
  .quiet_ok   (quiet_ok_w),
  .force_ok   (force_ok_w),
  .busy       (busy_q)
);

// File: tb/save_autosave_sched_test.sv
`timescale 1ns/1ps
module save_autosave_sched_test;
  localparam int SUM_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sum_valid = 1'b0;
  logic [SUM_W-1:0] sum_data = '0;
  logic             tick_ms = 1'b0;
  logic             reset_btn = 1'b0;
  logic             save_done = 1'b0;
  logic             save_req;

  int checks = 0;
  int failures = 0;
  int nreq = 0;

  always #2 clk = ~clk;

  save_autosave_sched #(
    .SUM_W(SUM_W), .QUIET_MS(4), .FORCE_MS(12), .HOLD_MS(3)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sum_valid(sum_valid), .sum_data(sum_data),
    .tick_ms(tick_ms), .reset_btn(reset_btn), .save_done(save_done),
    .save_req(save_req)
  );

  always @(negedge clk) if (rst_n && save_req) nreq++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    tick_ms = 1'b1; @(negedge clk); tick_ms = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick(); cyc(1); end
  endtask

  task automatic send(input logic [SUM_W-1:0] v);
    sum_valid = 1'b1; sum_data = v; @(negedge clk); sum_valid = 1'b0;
  endtask

  task automatic ack();
    save_done = 1'b1; @(negedge clk); save_done = 1'b0; cyc(2);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 save_req after reset", save_req, 0);
    chk("R1 request count after reset", nreq, 0);
  endtask

  task automatic t_first_ref();
    send(16'h1111); ticks(10); cyc(3);
    chk("R2 first pass is reference", nreq, 0);
  endtask

  task automatic t_quiet();
    send(16'h2222); ticks(3); cyc(3);
    chk("R4 no save before quiet time", nreq, 0);
    tick(); cyc(3);
    chk("R4 R7 one save after quiet time", nreq, 1);
    ticks(6); cyc(2);
    chk("R8 no reissue while outstanding", nreq, 1);
    ack(); ticks(8); cyc(2);
    chk("R9 clean after commit", nreq, 1);
  endtask

  task automatic t_revert();
    send(16'h3333); ticks(2); send(16'h2222); ticks(14); cyc(3);
    chk("R3 reverted value causes no save", nreq, 1);
  endtask

  task automatic t_force();
    send(16'h4000);
    for (int k = 1; k <= 12; k++) begin
      tick(); cyc(1);
      if (k == 11) begin cyc(2); chk("R5 no force before ceiling", nreq, 1); end
      if (k < 12 && (k % 2) == 0) send(16'h4000 + 16'(k));
    end
    cyc(3);
    chk("R5 forced save at ceiling", nreq, 2);
    send(16'h5000);
    ack();
    for (int k = 1; k <= 12; k++) begin
      tick(); cyc(1);
      if (k == 11) begin cyc(2); chk("R10 ceiling restarted after save", nreq, 2); end
      if (k < 12 && (k % 2) == 0) send(16'h5000 + 16'(k));
    end
    cyc(3);
    chk("R10 second forced save", nreq, 3);
    ack(); ticks(8); cyc(2);
    chk("R9 issue-time value committed", nreq, 3);
  endtask

  task automatic t_ref_issue();
    send(16'h6666); ticks(4); cyc(3);
    chk("R4 save of 6666", nreq, 4);
    send(16'h7777); cyc(2); ack();
    ticks(3); cyc(3);
    chk("R9 quiet wait for later value", nreq, 4);
    tick(); cyc(3);
    chk("R9 later value still seen as change", nreq, 5);
    ack();
  endtask

  task automatic t_long_press();
    reset_btn = 1'b1; ticks(3); cyc(3);
    chk("R6 no save at threshold", nreq, 5);
    tick(); cyc(4);
    chk("R6 save when held past threshold", nreq, 6);
    ticks(6); ack(); ticks(2); cyc(2);
    chk("R6 one save per press", nreq, 6);
    reset_btn = 1'b0; cyc(3);
    reset_btn = 1'b1; ticks(3); reset_btn = 1'b0; cyc(4);
    chk("R6 short press ignored", nreq, 6);
  endtask

  task automatic t_manual_busy();
    send(16'h8888); ticks(4); cyc(3);
    chk("R4 save of 8888", nreq, 7);
    reset_btn = 1'b1; ticks(4); cyc(4);
    chk("R8 press held off while outstanding", nreq, 7);
    reset_btn = 1'b0;
    ack(); cyc(2);
    chk("R8 held press served after done", nreq, 8);
    ack();
    ack(); cyc(2);
    chk("R8 stray done ignored", nreq, 8);
    send(16'h9999); ticks(4); cyc(3);
    chk("R8 normal save after stray done", nreq, 9);
    ack();
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_first_ref();
    t_quiet();
    t_revert();
    t_force();
    t_ref_issue();
    t_long_press();
    t_manual_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule